// File: doc/BRIEF.md
# Two-Stage Bus Watchdog Timer

This block is a watchdog timer that software reaches over an APB slave port using 32-bit word transfers. A down-counter decrements once in each cycle that the watchdog clock-enable input is high. When the count runs out for the first time, the block raises an interrupt flag and starts the count again from the programmed reload value. If software does not service that interrupt and the count runs out a second time, the block raises a reset request and the counter stops.

Software services the watchdog by writing the clear register, which drops the interrupt flag and restarts the count. Separate enables gate the interrupt output and the reset output. A lock register protects the configuration: all other registers ignore writes until a fixed key value is written to the lock. An integration-test mode lets software drive both outputs directly, so that board-level wiring can be checked without waiting for an expiry.

Top module: `wdog_apb`

## Requirements
- R1: After reset, control, the interrupt and reset flags, the lock and both integration registers are zero. The reload value (offset 0x00) and the count (offset 0x04) read 0xFFFFFFFF, and the counter is running.
- R2: A write to offset 0x00 sets both the reload value and the count to the written data and starts the counter. While the counter runs, the count drops by one in every cycle in which `wd_tick` is high.
- R3: A tick that takes the count from 1 to 0 is an expiry. If the raw interrupt flag (bit 0 at offset 0x10) is clear, the expiry sets it. The next tick loads the count from the reload value.
- R4: An expiry while the raw interrupt flag is already set sets the reset flag and halts the counter at zero. The reset flag stays set until the block is reset.
- R5: Any write to offset 0x0C clears the raw interrupt flag and copies the reload value into the count. In that cycle it takes priority over a tick. It does not restart a halted counter.
- R6: Control (offset 0x08) keeps only bit 0 (interrupt enable) and bit 1 (reset enable). Its other bits read zero. Masked status (bit 0 at offset 0x14) and `wd_irq` equal the raw flag AND bit 0. `wd_rst_req` equals the reset flag AND bit 1.
- R7: Writing 0x1ACCE551 to offset 0xC00 unlocks the block and writing any other value locks it. Reading 0xC00 returns 1 when locked and 0 when unlocked.
- R8: While the block is locked, writes to every offset except 0xC00 have no effect.
- R9: While bit 0 at offset 0xF00 is set, `wd_irq` follows bit 1 at offset 0xF04 and `wd_rst_req` follows bit 0 at offset 0xF04, overriding the normal status. Offset 0xF00 reads back its bit 0.
- R10: Offsets 0x0C, 0xF04 and all unmapped offsets read zero. Writes to 0x04, 0x10, 0x14 and unmapped offsets have no effect.
- R11: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer ready, tied high |
| pslverr | output | 1 | Transfer error, tied low |
| wd_tick | input | 1 | Counter clock enable |
| wd_irq | output | 1 | Interrupt output |
| wd_rst_req | output | 1 | Reset request output |

## Verification
The assertions assume that the bus follows the APB protocol. Each write is one cycle with `psel` alone, followed by one cycle with `psel` and `penable` both high, and the address and data stay steady across the two cycles. Addresses are word aligned. `wd_tick` may take any value in any cycle. The bench issues every transfer through a single two-phase task, so it never breaks these rules. In one write it raises `wd_tick` only in the access cycle, which lines a service write up against an expiry on purpose.

// File: rtl/wdog_pkg.sv
// Package: shared constants, register select type and address decoder
// for the two-stage watchdog. Assumes word-aligned byte addresses.
package wdog_pkg;

    parameter int WD_ADDR_W = 12;
    parameter int WD_DATA_W = 32;

    localparam logic [WD_ADDR_W-1:0] OFF_RELOAD  = 12'h000;
    localparam logic [WD_ADDR_W-1:0] OFF_COUNT   = 12'h004;
    localparam logic [WD_ADDR_W-1:0] OFF_CTRL    = 12'h008;
    localparam logic [WD_ADDR_W-1:0] OFF_SERVICE = 12'h00C;
    localparam logic [WD_ADDR_W-1:0] OFF_RAW     = 12'h010;
    localparam logic [WD_ADDR_W-1:0] OFF_MASKED  = 12'h014;
    localparam logic [WD_ADDR_W-1:0] OFF_LOCK    = 12'hC00;
    localparam logic [WD_ADDR_W-1:0] OFF_TESTEN  = 12'hF00;
    localparam logic [WD_ADDR_W-1:0] OFF_TESTOUT = 12'hF04;

    localparam logic [WD_DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

    // Index of each output inside the output vector (matches test register bits)
    localparam int OUT_RST = 0;
    localparam int OUT_IRQ = 1;
    localparam int NUM_OUT = 2;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_RELOAD,
        SEL_COUNT,
        SEL_CTRL,
        SEL_SERVICE,
        SEL_RAW,
        SEL_MASKED,
        SEL_LOCK,
        SEL_TESTEN,
        SEL_TESTOUT
    } wd_sel_e;

    // Map a byte address onto a register select
    function automatic wd_sel_e wd_decode(input logic [WD_ADDR_W-1:0] a);
        case (a)
            OFF_RELOAD:  return SEL_RELOAD;
            OFF_COUNT:   return SEL_COUNT;
            OFF_CTRL:    return SEL_CTRL;
            OFF_SERVICE: return SEL_SERVICE;
            OFF_RAW:     return SEL_RAW;
            OFF_MASKED:  return SEL_MASKED;
            OFF_LOCK:    return SEL_LOCK;
            OFF_TESTEN:  return SEL_TESTEN;
            OFF_TESTOUT: return SEL_TESTOUT;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/wdog_regs.sv
// Module: wdog_regs
// Register file and bus decode. It holds the control, lock and
// integration-test registers, turns APB writes into load and service strobes
// for the counter, and builds the read data.
// Assumes: a write takes effect in the access phase (psel & penable & pwrite).
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int DATA_W = WD_DATA_W,
    parameter int CNT_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [WD_ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0]    pwdata,
    input  logic [CNT_W-1:0]     cnt_i,
    input  logic [CNT_W-1:0]     reload_i,
    input  logic                 irq_flag_i,
    output logic                 lock_o,
    output logic [1:0]           ctrl_o,
    output logic                 testen_o,
    output logic [NUM_OUT-1:0]   testout_o,
    output logic                 load_wr_o,
    output logic                 svc_wr_o,
    output logic [DATA_W-1:0]    prdata_o
);

    wd_sel_e sel;
    logic    wr_acc;
    logic    wr_ok;

    // Decode the address and qualify writes against the lock
    always_comb begin
        sel       = wd_decode(paddr);
        wr_acc    = psel & penable & pwrite;
        wr_ok     = wr_acc & (~lock_o | (sel == SEL_LOCK));
        load_wr_o = wr_ok & (sel == SEL_RELOAD);
        svc_wr_o  = wr_ok & (sel == SEL_SERVICE);
    end

    // Store the software-visible configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o    <= '0;
            lock_o    <= 1'b0;
            testen_o  <= 1'b0;
            testout_o <= '0;
        end else if (wr_ok) begin
            case (sel)
                SEL_CTRL:    ctrl_o    <= pwdata[1:0];
                SEL_LOCK:    lock_o    <= (pwdata != UNLOCK_KEY);
                SEL_TESTEN:  testen_o  <= pwdata[0];
                SEL_TESTOUT: testout_o <= pwdata[NUM_OUT-1:0];
                default:     ;
            endcase
        end
    end

    // Build the read data; write-only and unmapped offsets return zero
    always_comb begin
        prdata_o = '0;
        case (sel)
            SEL_RELOAD: prdata_o[CNT_W-1:0] = reload_i;
            SEL_COUNT:  prdata_o[CNT_W-1:0] = cnt_i;
            SEL_CTRL:   prdata_o[1:0]       = ctrl_o;
            SEL_RAW:    prdata_o[0]         = irq_flag_i;
            SEL_MASKED: prdata_o[0]         = irq_flag_i & ctrl_o[0];
            SEL_LOCK:   prdata_o[0]         = lock_o;
            SEL_TESTEN: prdata_o[0]         = testen_o;
            default:    prdata_o            = '0;
        endcase
    end

endmodule

// File: rtl/wdog_counter.sv
// Module: wdog_counter
// Down-counter with two-stage expiry. The first expiry sets the interrupt
// flag. An expiry while that flag is set raises the reset flag and halts.
// Assumes: load and service strobes are never high in the same cycle.
module wdog_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_wr_i,
    input  logic             svc_wr_i,
    input  logic [CNT_W-1:0] load_data_i,
    output logic [CNT_W-1:0] reload_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o,
    output logic             irq_flag_o,
    output logic             rst_flag_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic expire;

    // An expiry is a counted tick from one to zero
    always_comb expire = run_o & tick_i & (cnt_o == CNT_ONE);

    // Advance the count and the flags; software writes win over ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_o   <= CNT_MAX;
            cnt_o      <= CNT_MAX;
            run_o      <= 1'b1;
            irq_flag_o <= 1'b0;
            rst_flag_o <= 1'b0;
        end else if (load_wr_i) begin
            reload_o <= load_data_i;
            cnt_o    <= load_data_i;
            run_o    <= 1'b1;
        end else if (svc_wr_i) begin
            irq_flag_o <= 1'b0;
            cnt_o      <= reload_o;
        end else if (run_o && tick_i) begin
            if (cnt_o == '0) begin
                cnt_o <= reload_o;
            end else begin
                cnt_o <= cnt_o - CNT_ONE;
            end
            if (expire) begin
                if (irq_flag_o) begin
                    rst_flag_o <= 1'b1;
                    run_o      <= 1'b0;
                end else begin
                    irq_flag_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wdog_outmux.sv
// Module: wdog_outmux
// Output stage: per output, chooses between the enabled status flag and the
// integration-test value. Purely combinational.
module wdog_outmux
    import wdog_pkg::*;
(
    input  logic [1:0]         ctrl_i,
    input  logic               irq_flag_i,
    input  logic               rst_flag_i,
    input  logic               testen_i,
    input  logic [NUM_OUT-1:0] testout_i,
    output logic [NUM_OUT-1:0] out_o
);

    logic [NUM_OUT-1:0] flags;
    logic [NUM_OUT-1:0] enables;

    // Line up flags and enables with the test-register bit order
    always_comb begin
        flags[OUT_RST]   = rst_flag_i;
        flags[OUT_IRQ]   = irq_flag_i;
        enables[OUT_RST] = ctrl_i[1];
        enables[OUT_IRQ] = ctrl_i[0];
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        // Select test override or gated flag for output i
        assign out_o[i] = testen_i ? testout_i[i] : (flags[i] & enables[i]);
    end

endmodule

// File: rtl/wdog_apb.sv
// Module: wdog_apb (top)
// Two-stage watchdog on an APB slave port. It joins the register file,
// the counter and the output stage. Zero-wait, error-free transfers.
// Assumes: word-aligned 32-bit transfers; wd_tick is synchronous to pclk.
module wdog_apb
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 pclk,
    input  logic                 presetn,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [WD_ADDR_W-1:0] paddr,
    input  logic [WD_DATA_W-1:0] pwdata,
    output logic [WD_DATA_W-1:0] prdata,
    output logic                 pready,
    output logic                 pslverr,
    input  logic                 wd_tick,
    output logic                 wd_irq,
    output logic                 wd_rst_req
);

    logic               lock_q;
    logic [1:0]         ctrl_q;
    logic               testen_q;
    logic [NUM_OUT-1:0] testout_q;
    logic               load_wr;
    logic               svc_wr;
    logic [CNT_W-1:0]   reload_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               run_q;
    logic               irq_flag_q;
    logic               rst_flag_q;
    logic [NUM_OUT-1:0] out_vec;

    wdog_regs #(.DATA_W(WD_DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk        (pclk),
        .rst_n      (presetn),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .cnt_i      (cnt_q),
        .reload_i   (reload_q),
        .irq_flag_i (irq_flag_q),
        .lock_o     (lock_q),
        .ctrl_o     (ctrl_q),
        .testen_o   (testen_q),
        .testout_o  (testout_q),
        .load_wr_o  (load_wr),
        .svc_wr_o   (svc_wr),
        .prdata_o   (prdata)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_counter (
        .clk         (pclk),
        .rst_n       (presetn),
        .tick_i      (wd_tick),
        .load_wr_i   (load_wr),
        .svc_wr_i    (svc_wr),
        .load_data_i (pwdata[CNT_W-1:0]),
        .reload_o    (reload_q),
        .cnt_o       (cnt_q),
        .run_o       (run_q),
        .irq_flag_o  (irq_flag_q),
        .rst_flag_o  (rst_flag_q)
    );

    wdog_outmux u_outmux (
        .ctrl_i     (ctrl_q),
        .irq_flag_i (irq_flag_q),
        .rst_flag_i (rst_flag_q),
        .testen_i   (testen_q),
        .testout_i  (testout_q),
        .out_o      (out_vec)
    );

    // Drive the fixed bus responses and the two outputs
    always_comb begin
        pready     = 1'b1;
        pslverr    = 1'b0;
        wd_irq     = out_vec[OUT_IRQ];
        wd_rst_req = out_vec[OUT_RST];
    end

endmodule

// File: rtl/wdog_apb_chk.sv
// Module: wdog_apb_chk
// Assertion checker bound into wdog_apb. It observes ports and the state
// that the submodules drive.
module wdog_apb_chk
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 psel,
    input logic                 penable,
    input logic                 pwrite,
    input logic [WD_ADDR_W-1:0] paddr,
    input logic [WD_DATA_W-1:0] pwdata,
    input logic                 pready,
    input logic                 pslverr,
    input logic                 irq_out,
    input logic                 lock_q,
    input logic [1:0]           ctrl_q,
    input logic                 testen_q,
    input logic [NUM_OUT-1:0]   testout_q,
    input logic [CNT_W-1:0]     reload_q,
    input logic [CNT_W-1:0]     cnt_q,
    input logic                 run_q,
    input logic                 irq_flag_q,
    input logic                 rst_flag_q
);

    logic wr;
    always_comb wr = psel & penable & pwrite;

    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !lock_q && paddr == OFF_RELOAD)
        |=> (cnt_q == $past(pwdata[CNT_W-1:0])) && (reload_q == $past(pwdata[CNT_W-1:0])) && run_q);

    a_r4_reset_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rst_flag_q |=> rst_flag_q);

    a_r4_second_stage: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_flag_q) |-> ($past(irq_flag_q) && !run_q && cnt_q == '0));

    a_r4_halted_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr) |=> $stable(cnt_q));

    a_r5_service_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !lock_q && paddr == OFF_SERVICE) |=> (!irq_flag_q && cnt_q == $past(reload_q)));

    a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!testen_q && !ctrl_q[0]) |-> !irq_out);

    a_r8_locked_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && lock_q && paddr != OFF_LOCK)
        |=> ($stable(ctrl_q) && $stable(reload_q) && $stable(testen_q) && $stable(testout_q) && lock_q));

    a_r11_bus_ok: assert property (@(posedge clk) disable iff (!rst_n)
        pready && !pslverr);

endmodule

bind wdog_apb wdog_apb_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (pclk),
    .rst_n      (presetn),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .pwdata     (pwdata),
    .pready     (pready),
    .pslverr    (pslverr),
    .irq_out    (wd_irq),
    .lock_q     (lock_q),
    .ctrl_q     (ctrl_q),
    .testen_q   (testen_q),
    .testout_q  (testout_q),
    .reload_q   (reload_q),
    .cnt_q      (cnt_q),
    .run_q      (run_q),
    .irq_flag_q (irq_flag_q),
    .rst_flag_q (rst_flag_q)
);

// File: tb/wdog_apb_bench.sv
// Bench: behavioural reference model compared on every clock, plus named
// register checks through the bus.
module wdog_apb_bench;

    localparam int CLK_PERIOD = 10;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic        wd_tick = 1'b0;
    logic        wd_irq;
    logic        wd_rst_req;

    int vectors = 0;
    int misses = 0;
    bit finished = 0;

    // Reference model state
    bit [31:0] m_reload, m_cnt;
    bit        m_run, m_irq, m_rst, m_lock, m_ten;
    bit [1:0]  m_ctrl, m_tout;

    wdog_apb u_wdog_apb (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .wd_tick(wd_tick),
        .wd_irq(wd_irq), .wd_rst_req(wd_rst_req)
    );

    always #(CLK_PERIOD/2) pclk = ~pclk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Model update at each clock edge
    always @(posedge pclk) begin
        if (!presetn) begin
            m_reload = '1; m_cnt = '1; m_run = 1; m_irq = 0; m_rst = 0;
            m_lock = 0; m_ten = 0; m_ctrl = 0; m_tout = 0;
        end else begin
            bit took_wr;
            took_wr = 0;
            if (psel && penable && pwrite && (!m_lock || paddr == 12'hC00)) begin
                if (paddr == 12'h000) begin m_reload = pwdata; m_cnt = pwdata; m_run = 1; took_wr = 1; end
                else if (paddr == 12'h008) m_ctrl = pwdata[1:0];
                else if (paddr == 12'h00C) begin m_irq = 0; m_cnt = m_reload; took_wr = 1; end
                else if (paddr == 12'hC00) m_lock = (pwdata != 32'h1ACCE551);
                else if (paddr == 12'hF00) m_ten = pwdata[0];
                else if (paddr == 12'hF04) m_tout = pwdata[1:0];
            end
            if (!took_wr && m_run && wd_tick) begin
                if (m_cnt == 0) m_cnt = m_reload;
                else begin
                    if (m_cnt == 1) begin
                        if (m_irq) begin m_rst = 1; m_run = 0; end
                        else m_irq = 1;
                    end
                    m_cnt = m_cnt - 1;
                end
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h000: return m_reload;
            12'h004: return m_cnt;
            12'h008: return {30'd0, m_ctrl};
            12'h010: return {31'd0, m_irq};
            12'h014: return {31'd0, m_irq & m_ctrl[0]};
            12'hC00: return {31'd0, m_lock};
            12'hF00: return {31'd0, m_ten};
            default: return 32'd0;
        endcase
    endfunction

    // Compare outputs against the model away from the active edge
    always @(negedge pclk) begin
        if (presetn && !finished) begin
            chk("R6/R9 irq", {31'd0, wd_irq}, {31'd0, m_ten ? m_tout[1] : (m_irq & m_ctrl[0])});
            chk("R6/R9 rst", {31'd0, wd_rst_req}, {31'd0, m_ten ? m_tout[0] : (m_rst & m_ctrl[1])});
            chk("R11 bus", {30'd0, pready, pslverr}, 32'd2);
        end
    end

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d, input bit tick_acc = 0);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        if (tick_acc) wd_tick = 0;
        @(negedge pclk);
        penable = 1;
        if (tick_acc) wd_tick = 1;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
        if (tick_acc) wd_tick = 0;
    endtask

    task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge pclk);
        penable = 1;
        #1;
        d = prdata;
        chk("model read", d, m_read(a));
        @(negedge pclk);
        psel = 0; penable = 0;
    endtask

    task automatic rd_expect(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        apb_read(a, d);
        chk(req, d, exp);
    endtask

    task automatic block_reset();
        @(negedge pclk);
        presetn = 0;
        repeat (3) @(negedge pclk);
        presetn = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            misses++;
            $display("FAIL R11 watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        block_reset();
        // R1 reset state
        rd_expect("R1 reload", 12'h000, 32'hFFFFFFFF);
        rd_expect("R1 count", 12'h004, 32'hFFFFFFFF);
        rd_expect("R1 ctrl", 12'h008, 32'd0);
        rd_expect("R1 raw", 12'h010, 32'd0);
        rd_expect("R1 lock", 12'hC00, 32'd0);
        rd_expect("R1 testen", 12'hF00, 32'd0);

        // R2 load and count down, R3 first expiry, R4 second expiry
        apb_write(12'h008, 32'd3);
        wd_tick = 1;
        apb_write(12'h000, 32'd10);
        rd_expect("R2 reload", 12'h000, 32'd10);
        repeat (13) @(negedge pclk);
        chk("R3 irq out", {31'd0, wd_irq}, 32'd1);
        chk("R3 no reset yet", {31'd0, wd_rst_req}, 32'd0);
        rd_expect("R3 raw", 12'h010, 32'd1);
        rd_expect("R6 masked", 12'h014, 32'd1);
        repeat (10) @(negedge pclk);
        chk("R4 reset out", {31'd0, wd_rst_req}, 32'd1);
        rd_expect("R4 halted zero", 12'h004, 32'd0);
        repeat (5) @(negedge pclk);
        rd_expect("R4 still zero", 12'h004, 32'd0);

        // R5 service reloads, does not restart, reset flag stays
        apb_write(12'h00C, 32'd0);
        rd_expect("R5 raw cleared", 12'h010, 32'd0);
        repeat (4) @(negedge pclk);
        rd_expect("R5 count reloaded, halted", 12'h004, 32'd10);
        chk("R4 reset sticky", {31'd0, wd_rst_req}, 32'd1);

        // R6 enables gate the outputs
        block_reset();
        apb_write(12'h008, 32'd1);
        apb_write(12'h000, 32'd4);
        repeat (15) @(negedge pclk);
        chk("R6 reset gated off", {31'd0, wd_rst_req}, 32'd0);
        chk("R6 irq enabled", {31'd0, wd_irq}, 32'd1);
        apb_write(12'h008, 32'd2);
        chk("R6 reset enabled", {31'd0, wd_rst_req}, 32'd1);
        chk("R6 irq disabled", {31'd0, wd_irq}, 32'd0);
        rd_expect("R6 masked off", 12'h014, 32'd0);
        apb_write(12'h008, 32'hFFFFFFFF);
        rd_expect("R6 only two bits", 12'h008, 32'd3);

        // R5 service write wins over a tick that would expire
        wd_tick = 0;
        block_reset();
        apb_write(12'h000, 32'd1);
        apb_write(12'h00C, 32'd0, 1);
        rd_expect("R5 priority raw", 12'h010, 32'd0);
        rd_expect("R5 priority count", 12'h004, 32'd1);

        // R7 lock and R8 locked writes ignored
        apb_write(12'hC00, 32'd0);
        rd_expect("R7 locked", 12'hC00, 32'd1);
        apb_write(12'h008, 32'd3);
        rd_expect("R8 ctrl kept", 12'h008, 32'd0);
        apb_write(12'h000, 32'd7);
        rd_expect("R8 reload kept", 12'h000, 32'd1);
        apb_write(12'hF00, 32'd1);
        rd_expect("R8 testen kept", 12'hF00, 32'd0);
        apb_write(12'hC00, 32'h1ACCE550);
        rd_expect("R7 wrong key", 12'hC00, 32'd1);
        apb_write(12'hC00, 32'h1ACCE551);
        rd_expect("R7 unlocked", 12'hC00, 32'd0);

        // R9 integration override
        apb_write(12'hF04, 32'd2);
        apb_write(12'hF00, 32'd1);
        chk("R9 irq forced", {31'd0, wd_irq}, 32'd1);
        chk("R9 reset low", {31'd0, wd_rst_req}, 32'd0);
        apb_write(12'hF04, 32'd1);
        chk("R9 irq low", {31'd0, wd_irq}, 32'd0);
        chk("R9 reset forced", {31'd0, wd_rst_req}, 32'd1);
        rd_expect("R9 testen readback", 12'hF00, 32'd1);
        apb_write(12'hF00, 32'd0);
        chk("R9 override off", {31'd0, wd_rst_req}, 32'd0);

        // R10 write-only, read-only and unmapped offsets
        rd_expect("R10 service reads 0", 12'h00C, 32'd0);
        rd_expect("R10 testout reads 0", 12'hF04, 32'd0);
        apb_write(12'h004, 32'd55);
        rd_expect("R10 count not written", 12'h004, 32'd1);
        apb_write(12'h010, 32'd1);
        rd_expect("R10 raw not written", 12'h010, 32'd0);
        apb_write(12'h100, 32'hFFFFFFFF);
        rd_expect("R10 unmapped reads 0", 12'h100, 32'd0);
        rd_expect("R10 ctrl untouched", 12'h008, 32'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule